// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

An eight-bit general-purpose I/O port seen by a processor as three addressable registers. One register sets the direction of each pin, one holds the value driven on pins configured as outputs, and one reads the pin levels. Each pin drives a tri-state pad through an output value and an output enable. It samples the pad level through a two-flop synchronizer.

Each pin also has a peripheral select. When a pin's select is set, an on-chip peripheral takes over both the value driven on the pin and its direction. A peripheral can force the pin to be an output or force it to be an input. The direction register keeps, and reads back, its own stored value while the peripheral owns the pin. The synchronized pin levels always go to the peripheral data-in bus, whoever owns the pin.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset the direction register holds all ones and the output latch holds zero. `pin_oe` is zero and `bus_rdata` is zero.
- R2: With a pin's peripheral select low, a direction bit of 0 sets `pin_oe` for that pin and drives the latch bit on `pin_out`. A direction bit of 1 clears `pin_oe`. A direction write takes effect on `pin_oe` in the cycle after the write strobe.
- R3: A write strobe to address 0 (port) or to address 1 (latch) loads `bus_wdata` into the output latch. Address 2 is the direction register.
- R4: A read of address 1 returns the latch contents, independently of the pin levels.
- R5: A read of address 0 returns the pin levels after two synchronizer flops. A level present at `pin_in` at clock edge k reaches the synchronizer output at edge k+1. A read strobe sampled at edge k+2 or later returns it.
- R6: Read data is registered and appears one cycle after the read strobe. With no read strobe, `bus_rdata` holds its last value.
- R7: A read of address 2 returns the stored direction bits, even while a peripheral overrides pin direction.
- R8: With a pin's select high, `pin_out` carries that pin's `per_dout` bit instead of the latch bit.
- R9: With a pin's select high, `pin_oe` equals that pin's `per_oe` bit, whether that forces an output (1) or an input (0). With the select low, `per_oe` and `per_dout` have no effect.
- R10: `per_din` carries the synchronized pin levels, whatever the select bits are.
- R11: Address 3 is unused. A read of it returns zero, and a write to it changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| pin_out | output | WIDTH | Value driven to each pad |
| pin_oe | output | WIDTH | Pad output enable, 1 drives the pin |
| per_sel | input | WIDTH | Per-pin peripheral ownership select |
| per_dout | input | WIDTH | Peripheral output data |
| per_oe | input | WIDTH | Peripheral output enable, used only when selected |
| per_din | output | WIDTH | Synchronized pin levels for peripherals |

## Verification
The assertions assume that `per_sel` does not change between a direction write and the following cycle. They also assume that `pin_in` is only compared with the synchronizer once two clock edges have passed since reset. The bench changes pins and bus inputs only on the falling clock edge, and holds the select bits steady around every direction write. It never asserts a read and a write strobe in the same cycle. Each pin change is held for at least two edges before the next port read that depends on it.

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] per_sel,
  input  logic [WIDTH-1:0] per_dout,
  input  logic [WIDTH-1:0] per_oe,
  output logic [WIDTH-1:0] per_din
);

  localparam logic [1:0] A_PORT = 2'd0;
  localparam logic [1:0] A_LAT  = 2'd1;
  localparam logic [1:0] A_DIR  = 2'd2;

  logic [WIDTH-1:0] lat_q, dir_q, meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_PORT, A_LAT: lat_q <= bus_wdata;
        A_DIR:         dir_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_PORT:  bus_rdata <= sync_q;
        A_LAT:   bus_rdata <= lat_q;
        A_DIR:   bus_rdata <= dir_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_out[i] = per_sel[i] ? per_dout[i] : lat_q[i];
    assign pin_oe[i]  = per_sel[i] ? per_oe[i]   : ~dir_q[i];
  end

  assign per_din = sync_q;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_PORT || bus_addr == A_LAT)) |=> (lat_q == $past(bus_wdata)));

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR && per_sel == '0)
      |=> (per_sel != '0) || (pin_oe == ~$past(bus_wdata)));

  a_r7_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DIR) |=> (bus_rdata == $past(dir_q)));

  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r11_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> ($stable(lat_q) && $stable(dir_q)));

  a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (per_din == $past(pin_in, 2)));

endmodule

// File: tb/gpio_port_mux_tb_top.sv
module gpio_port_mux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0, per_sel = '0, per_dout = '0, per_oe = '0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe, per_din;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_mux #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .per_sel(per_sel), .per_dout(per_dout), .per_oe(per_oe),
    .per_din(per_din)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 dir reset", pin_oe, 8'h00);
    check("R1 rdata reset", bus_rdata, 8'h00);
    bus_read(2'd2);
    check("R1 dir all ones", bus_rdata, 8'hFF);
    bus_read(2'd1);
    check("R1 latch zero", bus_rdata, 8'h00);
  endtask

  task automatic t_port_drive;
    bus_write(2'd2, 8'hCF);
    check("R2 oe from dir", pin_oe, 8'h30);
    bus_write(2'd0, 8'hA5);
    check("R3 port addr writes latch", pin_out, 8'hA5);
    bus_write(2'd1, 8'h3C);
    check("R3 latch addr writes latch", pin_out, 8'h3C);
    bus_write(2'd2, 8'h00);
    check("R2 all outputs", pin_oe, 8'hFF);
  endtask

  task automatic t_latch_readback;
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    bus_read(2'd1);
    check("R4 latch readback", bus_rdata, 8'h3C);
    bus_read(2'd0);
    check("R4 port reads pins", bus_rdata, 8'h00);
  endtask

  task automatic t_sync;
    @(negedge clk);
    pin_in = 8'h5A;
    @(negedge clk);
    check("R5 one edge not yet", per_din, 8'h00);
    @(negedge clk);
    check("R10 two edges", per_din, 8'h5A);
    bus_read(2'd0);
    check("R5 port read", bus_rdata, 8'h5A);
    @(negedge clk);
    pin_in = 8'h81; bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R5 immediate read old", bus_rdata, 8'h5A);
    @(negedge clk);
    bus_read(2'd0);
    check("R5 later read new", bus_rdata, 8'h81);
  endtask

  task automatic t_rdata_hold;
    bus_read(2'd1);
    check("R6 latch read", bus_rdata, 8'h3C);
    bus_write(2'd1, 8'h99);
    repeat (2) @(negedge clk);
    check("R6 rdata holds", bus_rdata, 8'h3C);
  endtask

  task automatic t_override;
    bus_write(2'd2, 8'hFF);
    bus_write(2'd1, 8'hF0);
    @(negedge clk);
    per_sel = 8'h0F; per_oe = 8'h05; per_dout = 8'h0A;
    #1;
    check("R9 forced outputs", pin_oe, 8'h05);
    check("R8 peripheral data", pin_out, 8'hFA);
    bus_read(2'd2);
    check("R7 dir readback ff", bus_rdata, 8'hFF);
    @(negedge clk);
    per_sel = 8'h00;
    bus_write(2'd2, 8'h00);
    per_sel = 8'h0F; per_oe = 8'h00;
    #1;
    check("R9 forced inputs", pin_oe, 8'hF0);
    bus_read(2'd2);
    check("R7 dir readback 00", bus_rdata, 8'h00);
    @(negedge clk);
    per_sel = 8'h00;
    bus_write(2'd2, 8'hF0);
    per_oe = 8'hFF; per_dout = 8'hFF;
    #1;
    check("R9 oe ignored", pin_oe, 8'h0F);
    check("R9 dout ignored", pin_out, 8'hF0);
    per_sel = 8'hFF;
    pin_in = 8'h77;
    repeat (2) @(negedge clk);
    check("R10 din while owned", per_din, 8'h77);
    per_sel = 8'h00;
  endtask

  task automatic t_unused;
    bus_read(2'd3);
    check("R11 read zero", bus_rdata, 8'h00);
    bus_write(2'd3, 8'h12);
    bus_read(2'd1);
    check("R11 latch kept", bus_rdata, 8'hF0);
    bus_read(2'd2);
    check("R11 dir kept", bus_rdata, 8'hF0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_port_drive;
    t_latch_readback;
    t_sync;
    t_rdata_hold;
    t_override;
    t_unused;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule